// File: doc/BRIEF.md
# Register Result Status Rename Table

This block holds the architectural register file of a dynamically scheduled pipeline. Next to each register it keeps a producer tag, which names the station that will write that register. A tag of zero means that no instruction in flight targets the register. Instructions issue in order, one per cycle. On issue the block reads two source registers. For each source it returns one of two things: the stored value when nothing is pending, or the producer tag when a result is still owed. The issuing station then waits on that tag instead of on the register name. In the same cycle the block records the issuing station's tag against the destination register.

Execution units finish in any order and announce each result on a single broadcast bus as a tag and a data word. The block compares the broadcast tag with every register's producer tag. A register takes the data only while the broadcast tag is still its newest producer. A register that a later issue has re-targeted keeps waiting for its newer producer, so a late, stale result cannot overwrite a newer one. A lookup made in the same cycle as a matching broadcast is served from the bus. When an issue and a matching broadcast reach the same register in one cycle, the issue's new tag is the one that remains.

Top module: `rrs_rename_table`

## Requirements
- R1: After reset every register reads back as value zero with tag zero on both source ports.
- R2: A source register whose tag is zero returns its stored value on the value port and zero on the tag port.
- R3: A source register with a nonzero tag returns that tag on the tag port and zero on the value port.
- R4: An issue writes issueTag (always nonzero) into the destination register's tag, and a lookup in the next cycle sees that tag.
- R5: A broadcast whose tag equals a register's current tag writes the broadcast data into that register and sets its tag to zero.
- R6: A broadcast whose tag does not match a register's current tag leaves that register's value and tag unchanged. This covers the case of a register re-targeted by a later issue, which never takes the earlier producer's result.
- R7: A lookup in the same cycle as a matching broadcast returns the broadcast data with tag zero.
- R8: When an issue and a matching broadcast hit the same register in one cycle, the register afterwards holds the new issue tag.
- R9: Source lookups see the state from before the same instruction's destination update, so an instruction that reads its own destination gets the previous contents.
- R10: A broadcast with tag zero writes no register.
- R11: Producers pending on different registers may complete in any order, and each register gets its own producer's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction issues this cycle |
| issueDst | input | 4 | Destination register index |
| issueSrcA | input | 4 | First source register index |
| issueSrcB | input | 4 | Second source register index |
| issueTag | input | 4 | Tag of the station receiving the instruction, nonzero |
| bcastValid | input | 1 | A result is on the broadcast bus |
| bcastTag | input | 4 | Tag of the station producing the result |
| bcastData | input | 64 | Result data |
| srcAValue | output | 64 | First source value, zero while pending |
| srcATag | output | 4 | First source producer tag, zero when the value is valid |
| srcBValue | output | 64 | Second source value, zero while pending |
| srcBTag | output | 4 | Second source producer tag, zero when the value is valid |

## Verification
The hardest case to reach is a stale result: a register must be re-targeted while its first producer is still outstanding, and that first producer must then broadcast. The stimulus issues twice to one register with two different tags and broadcasts the older tag. It then reads the register back and expects the newer tag with the value unchanged. The same-cycle collisions come from placing an issue and a matching broadcast in one cycle, and a lookup and a matching broadcast in one cycle. These cases cover the new tag winning over the broadcast and the bypass from the bus.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // Strobes from the tag control to the value datapath
  typedef struct packed {
    logic bypassA;  // first source is served from the broadcast bus
    logic bypassB;  // second source is served from the broadcast bus
  } rrsStrobe_t;

endpackage

// File: rtl/rrs_tag_ctrl.sv
module rrs_tag_ctrl
  import rrs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [IDX_W-1:0]    issueDst,
  input  logic [IDX_W-1:0]    issueSrcA,
  input  logic [IDX_W-1:0]    issueSrcB,
  input  logic [TAG_W-1:0]    issueTag,
  input  logic                bcastValid,
  input  logic [TAG_W-1:0]    bcastTag,
  output logic [TAG_W-1:0]    srcATag,
  output logic [TAG_W-1:0]    srcBTag,
  output logic [NUM_REGS-1:0] wrEn,
  output rrsStrobe_t          strobe
);

  logic [TAG_W-1:0]    statusTab [NUM_REGS];
  logic [NUM_REGS-1:0] matchVec;
  logic [NUM_REGS-1:0] issueHit;
  logic                bcastLive;

  // Tag zero is blank and never names a producer (R10)
  assign bcastLive = bcastValid && (bcastTag != '0);

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gen_status
      assign matchVec[g] = bcastLive && (statusTab[g] == bcastTag);
      assign issueHit[g] = issueValid && (issueDst == IDX_W'(g));

      // The new issue tag takes precedence over a clearing broadcast (R8)
      always_ff @(posedge clk) begin
        if (!rstN)            statusTab[g] <= '0;
        else if (issueHit[g]) statusTab[g] <= issueTag;
        else if (matchVec[g]) statusTab[g] <= '0;
      end

      assert_tag_recorded_R4: assert property (@(posedge clk) disable iff (!rstN)
        (issueHit[g] && !matchVec[g]) |=> (statusTab[g] == $past(issueTag)));

      assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
        (matchVec[g] && !issueHit[g]) |=> (statusTab[g] == '0));

      assert_stale_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
        (!matchVec[g] && !issueHit[g]) |=> $stable(statusTab[g]));

      assert_issue_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
        (matchVec[g] && issueHit[g]) |=> (statusTab[g] == $past(issueTag)));
    end
  endgenerate

  assign wrEn = matchVec;

  // Lookup uses the state before this cycle's update (R9), with bypass (R7)
  logic [TAG_W-1:0] rawA, rawB;
  assign rawA = statusTab[issueSrcA];
  assign rawB = statusTab[issueSrcB];

  always_comb begin
    strobe.bypassA = matchVec[issueSrcA];
    strobe.bypassB = matchVec[issueSrcB];
    srcATag        = strobe.bypassA ? '0 : rawA;
    srcBTag        = strobe.bypassB ? '0 : rawB;
  end

  assert_issue_tag_nonblank_R4: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueTag != '0));

endmodule

// File: rtl/rrs_value_dp.sv
module rrs_value_dp
  import rrs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REGS-1:0] wrEn,
  input  rrsStrobe_t          strobe,
  input  logic [DATA_W-1:0]   bcastData,
  input  logic [IDX_W-1:0]    issueSrcA,
  input  logic [IDX_W-1:0]    issueSrcB,
  input  logic [TAG_W-1:0]    srcATag,
  input  logic [TAG_W-1:0]    srcBTag,
  output logic [DATA_W-1:0]   srcAValue,
  output logic [DATA_W-1:0]   srcBValue
);

  logic [DATA_W-1:0] valueTab [NUM_REGS];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gen_value
      always_ff @(posedge clk) begin
        if (!rstN)         valueTab[g] <= '0;
        else if (wrEn[g])  valueTab[g] <= bcastData;
      end

      assert_value_written_R5: assert property (@(posedge clk) disable iff (!rstN)
        wrEn[g] |=> (valueTab[g] == $past(bcastData)));

      assert_value_held_R6: assert property (@(posedge clk) disable iff (!rstN)
        !wrEn[g] |=> $stable(valueTab[g]));
    end
  endgenerate

  always_comb begin
    if (strobe.bypassA)      srcAValue = bcastData;
    else if (srcATag != '0)  srcAValue = '0;
    else                     srcAValue = valueTab[issueSrcA];

    if (strobe.bypassB)      srcBValue = bcastData;
    else if (srcBTag != '0)  srcBValue = '0;
    else                     srcBValue = valueTab[issueSrcB];
  end

  // A tag names at most one register, so a broadcast writes at most one (R11)
  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrEn));

  assert_pending_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (srcATag != '0) |-> (srcAValue == '0));

endmodule

// File: rtl/rrs_rename_table.sv
module rrs_rename_table
  import rrs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [IDX_W-1:0]  issueSrcA,
  input  logic [IDX_W-1:0]  issueSrcB,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastData,
  output logic [DATA_W-1:0] srcAValue,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcBValue,
  output logic [TAG_W-1:0]  srcBTag
);

  logic [NUM_REGS-1:0] wrEn;
  rrsStrobe_t          strobe;

  rrs_tag_ctrl #(
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W),
    .IDX_W    (IDX_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueDst   (issueDst),
    .issueSrcA  (issueSrcA),
    .issueSrcB  (issueSrcB),
    .issueTag   (issueTag),
    .bcastValid (bcastValid),
    .bcastTag   (bcastTag),
    .srcATag    (srcATag),
    .srcBTag    (srcBTag),
    .wrEn       (wrEn),
    .strobe     (strobe)
  );

  rrs_value_dp #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W),
    .IDX_W    (IDX_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .strobe    (strobe),
    .bcastData (bcastData),
    .issueSrcA (issueSrcA),
    .issueSrcB (issueSrcB),
    .srcATag   (srcATag),
    .srcBTag   (srcBTag),
    .srcAValue (srcAValue),
    .srcBValue (srcBValue)
  );

endmodule

// File: tb/test_rrs_rename_table.sv
`timescale 1ns/1ps
module test_rrs_rename_table;

  localparam int NR = 16;
  localparam int DW = 64;
  localparam int TW = 4;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          issueValid;
  logic [IW-1:0] issueDst, issueSrcA, issueSrcB;
  logic [TW-1:0] issueTag;
  logic          bcastValid;
  logic [TW-1:0] bcastTag;
  logic [DW-1:0] bcastData;
  logic [DW-1:0] srcAValue, srcBValue;
  logic [TW-1:0] srcATag, srcBTag;

  always #2 clk = ~clk;  // 250 MHz

  rrs_rename_table i_rrs_rename_table (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueDst(issueDst),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueTag(issueTag),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastData(bcastData),
    .srcAValue(srcAValue), .srcATag(srcATag),
    .srcBValue(srcBValue), .srcBTag(srcBTag)
  );

  typedef struct {
    logic [DW-1:0] vA;
    logic [TW-1:0] tA;
    logic [DW-1:0] vB;
    logic [TW-1:0] tB;
    string         req;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad   = 0;

  // Reference state derived from the requirements
  logic [DW-1:0] mVal [NR];
  logic [TW-1:0] mTag [NR];

  function automatic void expLookup(input logic [IW-1:0] s, input logic bv,
                                    input logic [TW-1:0] bt, input logic [DW-1:0] bd,
                                    output logic [DW-1:0] v, output logic [TW-1:0] t);
    if (mTag[s] != '0 && bv && bt == mTag[s]) begin v = bd; t = '0; end       // R7
    else if (mTag[s] != '0)                  begin v = '0; t = mTag[s]; end  // R3
    else                                     begin v = mVal[s]; t = '0; end  // R2
  endfunction

  // Drive one cycle, push the expected lookup, advance the reference model
  task automatic step(input logic iv, input int dst, input int sa, input int sb,
                      input int itag, input logic bv, input int btag,
                      input logic [DW-1:0] bd, input string req);
    expItem_t it;
    issueValid = iv;  issueDst = IW'(dst);
    issueSrcA = IW'(sa); issueSrcB = IW'(sb); issueTag = TW'(itag);
    bcastValid = bv;  bcastTag = TW'(btag); bcastData = bd;
    expLookup(IW'(sa), bv, TW'(btag), bd, it.vA, it.tA);
    expLookup(IW'(sb), bv, TW'(btag), bd, it.vB, it.tB);
    it.req = req;
    expQ.push_back(it);
    @(posedge clk);
    for (int r = 0; r < NR; r++) begin
      if (bv && btag != 0 && mTag[r] == TW'(btag)) begin  // R5, R10
        mVal[r] = bd; mTag[r] = '0;
      end
    end
    if (iv) mTag[dst] = TW'(itag);  // R4, R8
    #1;
  endtask

  task automatic idleRead(input int sa, input int sb, input string req);
    step(1'b0, 0, sa, sb, 1, 1'b0, 0, '0, req);
  endtask

  // Monitor: compare the lookup results away from the clock edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      total++;
      if (srcAValue !== it.vA || srcATag !== it.tA) begin
        bad++;
        $display("FAIL %s portA: got val=%h tag=%0d exp val=%h tag=%0d",
                 it.req, srcAValue, srcATag, it.vA, it.tA);
      end
      total++;
      if (srcBValue !== it.vB || srcBTag !== it.tB) begin
        bad++;
        $display("FAIL %s portB: got val=%h tag=%0d exp val=%h tag=%0d",
                 it.req, srcBValue, srcBTag, it.vB, it.tB);
      end
    end
  end

  initial begin
    #20000;
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) begin mVal[r] = '0; mTag[r] = '0; end
    rstN = 1'b0; issueValid = 1'b0; issueDst = '0; issueSrcA = '0; issueSrcB = '0;
    issueTag = '0; bcastValid = 1'b0; bcastTag = '0; bcastData = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: every register blank after reset
    for (int r = 0; r < NR; r += 2) idleRead(r, r + 1, "R1");

    // R4: record tag 5 on r3; R2 sources blank
    step(1'b1, 3, 0, 1, 5, 1'b0, 0, '0, "R2");
    idleRead(3, 2, "R4/R3");
    // R7: lookup of r3 while tag 5 broadcasts
    step(1'b0, 0, 3, 3, 1, 1'b1, 5, 64'hDEAD_BEEF_0000_0003, "R7");
    idleRead(3, 0, "R5");

    // R6: WAW on r4, stale tag 1 result must be ignored
    step(1'b1, 4, 0, 0, 1, 1'b0, 0, '0, "R6 setup");
    step(1'b1, 4, 4, 3, 2, 1'b0, 0, '0, "R6 setup");
    step(1'b0, 0, 4, 3, 1, 1'b1, 1, 64'h1111_1111_1111_1111, "R6 stale bcast");
    idleRead(4, 4, "R6");
    step(1'b0, 0, 4, 5, 1, 1'b1, 2, 64'h2222_2222_2222_2222, "R7 newer bcast");
    idleRead(4, 3, "R5 newer");

    // R8: issue r6 tag 7 while tag 3 of r6 broadcasts
    step(1'b1, 6, 0, 0, 3, 1'b0, 0, '0, "R8 setup");
    step(1'b1, 6, 1, 2, 7, 1'b1, 3, 64'h3333_0000_0000_3333, "R8 collide");
    idleRead(6, 4, "R8");
    step(1'b0, 0, 6, 6, 1, 1'b1, 7, 64'h7777_0000_0000_7777, "R8 finish");
    idleRead(6, 0, "R8 value");

    // R9: instruction reads its own destination
    step(1'b1, 4, 4, 4, 9, 1'b0, 0, '0, "R9");
    idleRead(4, 4, "R9 after");
    step(1'b1, 4, 4, 6, 12, 1'b0, 0, '0, "R9 pending");

    // R10: tag zero broadcast changes nothing
    step(1'b0, 0, 5, 3, 1, 1'b1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
    idleRead(5, 3, "R10 after");

    // R11: two producers complete out of order
    step(1'b1, 10, 0, 0, 10, 1'b0, 0, '0, "R11 setup");
    step(1'b1, 11, 10, 0, 11, 1'b0, 0, '0, "R11 setup");
    step(1'b0, 0, 10, 11, 1, 1'b1, 11, 64'hBBBB_0000_0000_0011, "R11 late first");
    idleRead(10, 11, "R11 mid");
    step(1'b0, 0, 10, 11, 1, 1'b1, 10, 64'hAAAA_0000_0000_0010, "R11 early last");
    idleRead(10, 11, "R11");
    step(1'b0, 0, 4, 0, 1, 1'b1, 12, 64'hCCCC_0000_0000_000C, "R7 drain");
    idleRead(4, 15, "R5 drain");

    @(posedge clk); #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule